// File: doc/BRIEF.md
# Power-Good System Reset Generator

This block produces an active-low system reset for a processor from a set of per-rail power-good levels and general-purpose digital inputs. Two masks pick which rails and which inputs take part. In level mode the reset is held asserted until every selected condition is good. It is then released after a programmable delay, and it is driven low again on the next clock edge when any selected condition fails. In pulse mode the output idles high and issues one low pulse of programmable width once the conditions have been good for the delay. All timing counts a one-cycle millisecond tick supplied from outside.

In level mode a watchdog can watch a strobe input from the processor. A start time runs from the release of the reset, and a shorter period runs between strobe edges. When either expires, the reset is driven low and released again after either the normal delay or a second, separately selected recovery delay.

Top module: `sysrst_gen`

## Requirements
- R1: While the block reset `rst_n` is low and afterwards until a release, `sys_rst_n` is low in level mode (`pulse_mode`=0) and high in pulse mode (`pulse_mode`=1).
- R2: A rail or input whose mask bit is 0 has no effect. Release needs every rail with mask 1 to have `rail_pg`=1 and every input with mask 1 to have `gpi`=1.
- R3: The release delay code `dly_sel` means 0 ticks for code 0 and 2^(k-1) ticks for code k in 1..16. Codes above 16 give 32768 ticks. Release follows a number of ticks equal to the delay, counted once all selected conditions are good.
- R4: In level mode, a selected condition going bad while `sys_rst_n` is high drives `sys_rst_n` low on the next clock edge.
- R5: A selected condition going bad while the delay is running restarts the delay count from zero.
- R6: In pulse mode, once conditions have been good for the delay, `sys_rst_n` goes low for `pulse_width` ticks and then returns high. It stays high when conditions later fail, and a new pulse follows only after conditions recover.
- R7: A `pulse_width` of 0 gives a pulse of 1 tick.
- R8: With `wd_en`=1 in level mode, if no `wdi` edge occurs within `wd_start` ticks of the release, `sys_rst_n` goes low and the release sequence runs again.
- R9: Every rising or falling edge of `wdi` restarts the watchdog count with `wd_period` ticks. If no edge occurs for that many ticks, the reset toggles as in R8.
- R10: After a watchdog timeout the release delay uses `gpi_dly_sel` when `wd_recover_sel`=1 and `dly_sel` when it is 0, with the same coding as R3.
- R11: With `wd_en`=0, or in pulse mode, the watchdog never drives the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| tick_ms | input | 1 | One-cycle millisecond tick |
| rail_pg | input | N_RAIL | Per-rail power-good levels |
| rail_mask | input | N_RAIL | Rail select, 1 = monitored |
| gpi | input | N_GPI | General-purpose inputs, 1 = asserted |
| gpi_mask | input | N_GPI | Input select, 1 = monitored |
| dly_sel | input | 5 | Release delay code |
| pulse_mode | input | 1 | 1 = pulse mode, 0 = level mode |
| pulse_width | input | PW_W | Pulse width in ticks |
| wd_en | input | 1 | Watchdog enable |
| wd_start | input | WD_W | Watchdog start time in ticks |
| wd_period | input | WD_W | Watchdog time between strobes in ticks |
| wd_recover_sel | input | 1 | Recovery delay select after timeout |
| gpi_dly_sel | input | 5 | Alternate recovery delay code |
| wdi | input | 1 | Watchdog strobe from the processor |
| sys_rst_n | output | 1 | Active-low system reset |

## Verification
The hardest case to reach is a watchdog timeout followed by a recovery release. The reset has to be released first. Then the strobe has to stop at a known tick, so that the start time, and later the strobe period, run out at a tick the bench can predict. The stimulus releases the reset with zero delay and then paces ticks and strobe edges one at a time. This pins the timeout to one tick. The recovery delay is then measured tick by tick under both recovery selections.

// File: rtl/sysrst_pkg.sv
package sysrst_pkg;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_DELAY = 2'd1,
        ST_PULSE = 2'd2,
        ST_RUN   = 2'd3
    } sysrst_st_e;

    // code 0 -> no delay, code k -> 2^(k-1) ticks, saturating at max_k
    function automatic logic [31:0] dly_ticks(input logic [31:0] code,
                                              input logic [31:0] max_k);
        logic [31:0] k;
        k = (code > max_k) ? max_k : code;
        if (k == 32'd0) return 32'd0;
        return 32'd1 << (k - 32'd1);
    endfunction

endpackage

// File: rtl/sysrst_cond.sv
module sysrst_cond #(
    parameter int N_RAIL = 4,
    parameter int N_GPI  = 4
) (
    input  logic [N_RAIL-1:0] rail_pg,
    input  logic [N_RAIL-1:0] rail_mask,
    input  logic [N_GPI-1:0]  gpi,
    input  logic [N_GPI-1:0]  gpi_mask,
    output logic              all_ok
);
    logic [N_RAIL-1:0] rail_good;
    logic [N_GPI-1:0]  gpi_good;

    for (genvar i = 0; i < N_RAIL; i++) begin : g_rail
        assign rail_good[i] = rail_pg[i] | ~rail_mask[i];
    end

    for (genvar j = 0; j < N_GPI; j++) begin : g_gpi
        assign gpi_good[j] = gpi[j] | ~gpi_mask[j];
    end

    assign all_ok = (&rail_good) & (&gpi_good);
endmodule

// File: rtl/sysrst_wdog.sv
module sysrst_wdog #(
    parameter int WD_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_ms,
    input  logic            arm,
    input  logic            wdi,
    input  logic [WD_W-1:0] wd_start,
    input  logic [WD_W-1:0] wd_period,
    output logic            timeout
);
    typedef struct packed {
        logic [WD_W-1:0] cnt;
        logic            wdi_prev;
        logic            to;
    } wd_s;

    wd_s cur_q, nxt_d;
    logic strobe;

    assign strobe = wdi ^ cur_q.wdi_prev;

    always_comb begin
        nxt_d          = cur_q;
        nxt_d.wdi_prev = wdi;
        nxt_d.to       = 1'b0;
        if (!arm) begin
            nxt_d.cnt = wd_start;
        end else if (strobe) begin
            nxt_d.cnt = wd_period;
        end else if (tick_ms) begin
            if (cur_q.cnt <= WD_W'(1)) begin
                nxt_d.to  = 1'b1;
                nxt_d.cnt = wd_start;
            end else begin
                nxt_d.cnt = cur_q.cnt - WD_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign timeout = cur_q.to;
endmodule

// File: rtl/sysrst_gen.sv
module sysrst_gen
    import sysrst_pkg::*;
#(
    parameter int N_RAIL  = 4,
    parameter int N_GPI   = 4,
    parameter int SEL_W   = 5,
    parameter int DLY_MAX = 16,
    parameter int PW_W    = 15,
    parameter int WD_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_ms,
    input  logic [N_RAIL-1:0] rail_pg,
    input  logic [N_RAIL-1:0] rail_mask,
    input  logic [N_GPI-1:0]  gpi,
    input  logic [N_GPI-1:0]  gpi_mask,
    input  logic [SEL_W-1:0]  dly_sel,
    input  logic              pulse_mode,
    input  logic [PW_W-1:0]   pulse_width,
    input  logic              wd_en,
    input  logic [WD_W-1:0]   wd_start,
    input  logic [WD_W-1:0]   wd_period,
    input  logic              wd_recover_sel,
    input  logic [SEL_W-1:0]  gpi_dly_sel,
    input  logic              wdi,
    output logic              sys_rst_n
);
    localparam int CNT_W = (DLY_MAX > PW_W) ? DLY_MAX : PW_W;

    typedef struct packed {
        sysrst_st_e       st;
        logic [CNT_W-1:0] cnt;
        logic             use_alt;
    } ctl_s;

    ctl_s        cur_q, nxt_d;
    logic        all_ok;
    logic        wd_to;
    logic        wd_arm;
    logic [31:0] dly_tgt;
    logic [31:0] pw_eff;
    logic [31:0] cnt_ext;

    sysrst_cond #(.N_RAIL(N_RAIL), .N_GPI(N_GPI)) cond_i (
        .rail_pg   (rail_pg),
        .rail_mask (rail_mask),
        .gpi       (gpi),
        .gpi_mask  (gpi_mask),
        .all_ok    (all_ok)
    );

    assign wd_arm = (cur_q.st == ST_RUN) && wd_en && !pulse_mode;

    sysrst_wdog #(.WD_W(WD_W)) wdog_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_ms   (tick_ms),
        .arm       (wd_arm),
        .wdi       (wdi),
        .wd_start  (wd_start),
        .wd_period (wd_period),
        .timeout   (wd_to)
    );

    assign dly_tgt = dly_ticks(32'(cur_q.use_alt ? gpi_dly_sel : dly_sel), 32'(DLY_MAX));
    assign pw_eff  = (pulse_width == '0) ? 32'd1 : 32'(pulse_width);
    assign cnt_ext = 32'(cur_q.cnt);

    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.st)
            ST_HOLD: begin
                if (all_ok) begin
                    nxt_d.st      = ST_DELAY;
                    nxt_d.cnt     = '0;
                    nxt_d.use_alt = 1'b0;
                end
            end
            ST_DELAY: begin
                if (!all_ok) begin
                    nxt_d.st      = ST_HOLD;
                    nxt_d.cnt     = '0;
                    nxt_d.use_alt = 1'b0;
                end else if (cnt_ext >= dly_tgt) begin
                    nxt_d.st  = pulse_mode ? ST_PULSE : ST_RUN;
                    nxt_d.cnt = '0;
                end else if (tick_ms) begin
                    nxt_d.cnt = cur_q.cnt + CNT_W'(1);
                end
            end
            ST_PULSE: begin
                if (cnt_ext >= pw_eff) begin
                    nxt_d.st  = ST_RUN;
                    nxt_d.cnt = '0;
                end else if (tick_ms) begin
                    nxt_d.cnt = cur_q.cnt + CNT_W'(1);
                end
            end
            ST_RUN: begin
                if (!all_ok) begin
                    nxt_d.st      = ST_HOLD;
                    nxt_d.cnt     = '0;
                    nxt_d.use_alt = 1'b0;
                end else if (wd_to && !pulse_mode) begin
                    nxt_d.st      = ST_DELAY;
                    nxt_d.cnt     = '0;
                    nxt_d.use_alt = wd_recover_sel;
                end
            end
            default: nxt_d.st = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.st      <= ST_HOLD;
            cur_q.cnt     <= '0;
            cur_q.use_alt <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign sys_rst_n = pulse_mode ? (cur_q.st != ST_PULSE) : (cur_q.st == ST_RUN);
endmodule

// File: rtl/sysrst_chk.sv
module sysrst_chk #(
    parameter int N_RAIL = 4,
    parameter int N_GPI  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pulse_mode,
    input logic              sys_rst_n,
    input logic [N_RAIL-1:0] rail_pg,
    input logic [N_RAIL-1:0] rail_mask,
    input logic [N_GPI-1:0]  gpi,
    input logic [N_GPI-1:0]  gpi_mask,
    input logic              wd_to
);
    logic ok;
    assign ok = (&(rail_pg | ~rail_mask)) && (&(gpi | ~gpi_mask));

    // R4: level mode, a failing condition while released asserts reset next edge
    a_r4_immediate_assert: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_mode && sys_rst_n && !ok) |=> (!sys_rst_n || pulse_mode));

    // R2: level-mode release only happens while the selected conditions are good
    a_r2_release_needs_ok: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sys_rst_n) && !pulse_mode && $stable(pulse_mode)) |-> $past(ok));

    // R6: a pulse only starts while the selected conditions are good
    a_r6_pulse_needs_ok: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sys_rst_n) && pulse_mode && $stable(pulse_mode)) |-> $past(ok));

    // R8: in level mode reset falls only on a failed condition or a watchdog timeout
    a_r8_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sys_rst_n) && !pulse_mode && $stable(pulse_mode)) |-> ($past(!ok) || $past(wd_to)));

    // R11: the watchdog stays quiet in pulse mode
    a_r11_no_wd_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_mode && $stable(pulse_mode)) |-> !wd_to);
endmodule

bind sysrst_gen sysrst_chk #(.N_RAIL(N_RAIL), .N_GPI(N_GPI)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pulse_mode (pulse_mode),
    .sys_rst_n  (sys_rst_n),
    .rail_pg    (rail_pg),
    .rail_mask  (rail_mask),
    .gpi        (gpi),
    .gpi_mask   (gpi_mask),
    .wd_to      (wd_to)
);

// File: tb/sysrst_gen_tb_top.sv
`timescale 1ns/1ps
module sysrst_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_ms = 1'b0;
    logic [3:0]  rail_pg = 4'b0000;
    logic [3:0]  rail_mask = 4'b1011;
    logic [3:0]  gpi = 4'b0000;
    logic [3:0]  gpi_mask = 4'b0011;
    logic [4:0]  dly_sel = 5'd0;
    logic        pulse_mode = 1'b0;
    logic [14:0] pulse_width = 15'd3;
    logic        wd_en = 1'b0;
    logic [15:0] wd_start = 16'd5;
    logic [15:0] wd_period = 16'd3;
    logic        wd_recover_sel = 1'b0;
    logic [4:0]  gpi_dly_sel = 5'd0;
    logic        wdi = 1'b0;
    logic        sys_rst_n;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    sysrst_gen dut_i (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms),
        .rail_pg(rail_pg), .rail_mask(rail_mask), .gpi(gpi), .gpi_mask(gpi_mask),
        .dly_sel(dly_sel), .pulse_mode(pulse_mode), .pulse_width(pulse_width),
        .wd_en(wd_en), .wd_start(wd_start), .wd_period(wd_period),
        .wd_recover_sel(wd_recover_sel), .gpi_dly_sel(gpi_dly_sel), .wdi(wdi),
        .sys_rst_n(sys_rst_n)
    );

    // delay code stimulus and expected tick count
    localparam int NV = 6;
    localparam int VCODE [NV] = '{0, 1, 2, 3, 5, 8};
    localparam int VTCK  [NV] = '{0, 1, 2, 4, 16, 128};

    task automatic check(input string req, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: sys_rst_n actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick_ms = 1'b1;
            @(negedge clk) tick_ms = 1'b0;
        end
    endtask

    task automatic set_good(input logic g);
        @(negedge clk);
        rail_pg = g ? 4'b1011 : 4'b0011;
        gpi     = g ? 4'b0011 : 4'b0001;
    endtask

    task automatic do_reset(input logic pm);
        @(negedge clk);
        rst_n = 1'b0;
        pulse_mode = pm;
        rail_pg = 4'b0000;
        gpi = 4'b0000;
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        cyc(2);
        check("R1 level mode during block reset", sys_rst_n, 1'b0);
        rst_n = 1'b1;
        cyc(3);
        check("R1 level mode after block reset", sys_rst_n, 1'b0);

        // R3 delay code table
        for (int v = 0; v < NV; v++) begin
            set_good(1'b0);
            cyc(3);
            dly_sel = 5'(VCODE[v]);
            set_good(1'b1);
            cyc(2);
            if (VTCK[v] > 0) begin
                ticks(VTCK[v] - 1);
                cyc(3);
                check($sformatf("R3 code %0d one tick early", VCODE[v]), sys_rst_n, 1'b0);
                ticks(1);
            end
            cyc(3);
            check($sformatf("R3 code %0d released", VCODE[v]), sys_rst_n, 1'b1);
        end

        // R2 masked rail and input ignored
        rail_pg[2] = 1'b0; gpi[3] = 1'b0;
        cyc(4);
        check("R2 unselected bits dropped", sys_rst_n, 1'b1);
        rail_pg[2] = 1'b1; gpi[2] = 1'b1;
        cyc(4);
        check("R2 unselected bits raised", sys_rst_n, 1'b1);

        // R4 immediate assertion
        @(negedge clk) rail_pg[0] = 1'b0;
        @(negedge clk);
        check("R4 asserted one edge after rail fail", sys_rst_n, 1'b0);
        rail_pg[0] = 1'b1;
        dly_sel = 5'd0;
        cyc(4);
        check("R4 re-released", sys_rst_n, 1'b1);
        @(negedge clk) gpi[1] = 1'b0;
        @(negedge clk);
        check("R4 asserted one edge after gpi fail", sys_rst_n, 1'b0);

        // R2 not released while a selected input is bad
        rail_pg = 4'b1111;
        cyc(6);
        check("R2 held while selected gpi bad", sys_rst_n, 1'b0);

        // R5 restart of delay
        dly_sel = 5'd3;
        set_good(1'b1);
        cyc(2);
        ticks(3);
        set_good(1'b0);
        set_good(1'b1);
        cyc(2);
        ticks(3);
        cyc(3);
        check("R5 delay restarted after fail", sys_rst_n, 1'b0);
        ticks(1);
        cyc(3);
        check("R5 released after full delay", sys_rst_n, 1'b1);

        // R11 watchdog disabled
        ticks(20);
        cyc(2);
        check("R11 no toggle with wd_en=0", sys_rst_n, 1'b1);

        // R8 start time, R10 alternate recovery delay
        set_good(1'b0);
        wd_en = 1'b1; dly_sel = 5'd0;
        wd_recover_sel = 1'b1; gpi_dly_sel = 5'd2;
        set_good(1'b1);
        cyc(4);
        check("R8 released before start time", sys_rst_n, 1'b1);
        ticks(4);
        cyc(2);
        check("R8 high one tick before start time", sys_rst_n, 1'b1);
        dly_sel = 5'd5;
        ticks(1);
        cyc(3);
        check("R8 toggled at start time", sys_rst_n, 1'b0);
        ticks(1);
        cyc(3);
        check("R10 alt delay one tick early", sys_rst_n, 1'b0);
        ticks(1);
        cyc(3);
        check("R10 alt delay released", sys_rst_n, 1'b1);

        // R9 strobes keep it alive, then period runs out
        for (int s = 0; s < 10; s++) begin
            @(negedge clk) wdi = ~wdi;
            ticks(2);
        end
        cyc(2);
        check("R9 strobes hold release", sys_rst_n, 1'b1);
        @(negedge clk) wdi = ~wdi;
        ticks(2);
        cyc(2);
        check("R9 high before period", sys_rst_n, 1'b1);
        wd_recover_sel = 1'b0;
        ticks(1);
        cyc(3);
        check("R9 toggled at period", sys_rst_n, 1'b0);
        // R10 with normal delay (code 5 = 16 ticks); strobes ignored while asserted
        ticks(15);
        cyc(3);
        check("R10 normal delay one tick early", sys_rst_n, 1'b0);
        ticks(1);
        cyc(3);
        check("R10 normal delay released", sys_rst_n, 1'b1);
        wd_en = 1'b0;

        // R6 pulse mode
        do_reset(1'b1);
        check("R1 pulse mode idle high", sys_rst_n, 1'b1);
        wd_en = 1'b1; wd_start = 16'd2;
        dly_sel = 5'd2; pulse_width = 15'd3;
        set_good(1'b1);
        cyc(2);
        ticks(1);
        cyc(3);
        check("R6 high during delay", sys_rst_n, 1'b1);
        ticks(1);
        cyc(3);
        check("R6 pulse started", sys_rst_n, 1'b0);
        ticks(2);
        cyc(3);
        check("R6 pulse still low", sys_rst_n, 1'b0);
        ticks(1);
        cyc(3);
        check("R6 pulse ended", sys_rst_n, 1'b1);
        ticks(8);
        cyc(2);
        check("R11 no watchdog in pulse mode", sys_rst_n, 1'b1);
        set_good(1'b0);
        cyc(3);
        check("R6 stays high on fail", sys_rst_n, 1'b1);

        // R7 zero width clamp
        pulse_width = 15'd0;
        dly_sel = 5'd0;
        set_good(1'b1);
        cyc(3);
        check("R7 pulse of zero width starts", sys_rst_n, 1'b0);
        ticks(1);
        cyc(3);
        check("R7 clamped to one tick", sys_rst_n, 1'b1);
        wd_en = 1'b0;

        // R3 saturation: code 20 behaves as 32768 ticks
        do_reset(1'b0);
        dly_sel = 5'd20;
        set_good(1'b1);
        cyc(2);
        ticks(32767);
        cyc(3);
        check("R3 saturated code one tick early", sys_rst_n, 1'b0);
        ticks(1);
        cyc(3);
        check("R3 saturated code released", sys_rst_n, 1'b1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule